// File: doc/BRIEF.md
# Bipolar Violation and Excess-Zero Monitor

This block sits behind a bipolar line receiver running either B8ZS (T1) or HDB3 (E1) coding. Each bit period, marked by a bit enable, it takes the positive-rail and negative-rail pulses. It produces single-cycle increment pulses for line code violations and for excess-zero runs. A 16-bit error counter accumulates those pulses. The counter saturates at all ones and is cleared when it is read.

One control input, `zcs_excl`, sets two things at once. When high, bipolar violations that belong to a zero-substitution code are not counted, and the excess-zero threshold is 8 zeros. When low, every violation is counted and the threshold is 16 zeros.

The control only affects error reporting. No decoded data passes through the block.

B8ZS substitutions can only be recognised once all eight symbols have arrived. For this reason, every violation is reported a fixed eight bit periods after its own symbol, in both modes.

Top module: `lcv_monitor`

## Requirements
- R1: After reset, `bpv_pulse` and `exz_pulse` are low and `err_count` is zero.
- R2: A mark is a bit period with exactly one rail high. Its polarity is positive when `rail_p` is high. A mark is a violation when it has the same polarity as the previous mark; the first mark after reset is never a violation. With `zcs_excl` low, every violation gives one `bpv_pulse`, in the clock after the edge that accepts the eighth later bit.
- R3: In B8ZS mode (`hdb3_mode`=0) with `zcs_excl` high, no pulse is given for the two violations of a completed eight-symbol group zero,zero,zero,V,B,zero,V,B. Here V is a violation and B is a non-violating mark. Any other violation is still reported.
- R4: In HDB3 mode (`hdb3_mode`=1) with `zcs_excl` high, no pulse is given for a violation whose two preceding bit periods were both zeros. Any other violation is still reported.
- R5: With `zcs_excl` low, `exz_pulse` rises once per zero run, in the clock after the edge that accepts the 16th consecutive zero.
- R6: With `zcs_excl` high, `exz_pulse` rises once per zero run, in the clock after the edge that accepts the 8th consecutive zero.
- R7: A clock with `bit_en` low accepts no symbol and produces no pulse in the following clock.
- R8: Without a read, `err_count` grows by the number of pulses (0, 1 or 2) visible in the previous clock.
- R9: `err_count` saturates at all ones and holds there.
- R10: A clock with `rd_clr` high loads `err_count` with the number of pulses visible in that clock, so no pulse is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One bit period is accepted on this edge |
| rail_p | input | 1 | Positive-rail pulse |
| rail_n | input | 1 | Negative-rail pulse |
| hdb3_mode | input | 1 | 0 = B8ZS, 1 = HDB3 |
| zcs_excl | input | 1 | Exclude code violations, 8-zero threshold |
| rd_clr | input | 1 | Read strobe: clears the counter |
| bpv_pulse | output | 1 | Reported violation |
| exz_pulse | output | 1 | Excess-zero run reached |
| err_count | output | CNT_W | Saturating error count |

## Verification
A violation leaves the eight-symbol window just as its own bit is followed by eight zeros. With `zcs_excl` high, that eighth zero also completes an excess-zero run. So `bpv_pulse` and `exz_pulse` rise in the same clock, and the counter must add two. The bench provokes this directly with a violation followed by eight zeros. It also meets the case in random traffic, and it puts a read strobe on such cycles. Each cycle, the bench's count model folds both pulses into the expected value, and a read is expected to keep both.

// File: rtl/lcv_monitor.sv
module lcv_monitor #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rail_p,
  input  logic             rail_n,
  input  logic             hdb3_mode,
  input  logic             zcs_excl,
  input  logic             rd_clr,
  output logic             bpv_pulse,
  output logic             exz_pulse,
  output logic [CNT_W-1:0] err_count
);
  localparam int WIN = 8;
  localparam logic [WIN-1:0] B8_SHAPE = 8'b0001_1011;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [4:0] ZSAT = 5'd16;

  logic [WIN-1:0]   mk_q, vr_q, pd_q;
  logic             last_pol_q, seen_q;
  logic [4:0]       zrun_q;
  logic             bpv_q, exz_q;
  logic [CNT_W-1:0] cnt_q;

  wire mark_in = rail_p ^ rail_n;
  wire viol_in = mark_in & seen_q & (rail_p == last_pol_q);
  wire hdb_ok  = hdb3_mode & zcs_excl & ~mk_q[0] & ~mk_q[1];

  wire [WIN-1:0] mk_n = {mk_q[WIN-2:0], mark_in};
  wire [WIN-1:0] vr_n = {vr_q[WIN-2:0], viol_in};
  wire b8_hit = ~hdb3_mode & zcs_excl & (mk_n == B8_SHAPE)
              & vr_n[4] & ~vr_n[3] & vr_n[1] & ~vr_n[0];

  logic [WIN-1:0] pd_n;
  always_comb begin
    pd_n = {pd_q[WIN-2:0], viol_in & ~hdb_ok};
    if (b8_hit) begin
      pd_n[4] = 1'b0;
      pd_n[1] = 1'b0;
    end
  end

  wire [4:0] thr  = zcs_excl ? 5'd8 : ZSAT;
  wire [4:0] zinc = zrun_q + 5'd1;
  wire       exz_hit = ~mark_in & (zinc == thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_q       <= '0;
      vr_q       <= '0;
      pd_q       <= '0;
      last_pol_q <= 1'b0;
      seen_q     <= 1'b0;
      zrun_q     <= '0;
      bpv_q      <= 1'b0;
      exz_q      <= 1'b0;
    end else if (bit_en) begin
      mk_q   <= mk_n;
      vr_q   <= vr_n;
      pd_q   <= pd_n;
      bpv_q  <= pd_q[WIN-1];
      exz_q  <= exz_hit;
      zrun_q <= mark_in ? 5'd0 : ((zrun_q == ZSAT) ? ZSAT : zinc);
      if (mark_in) begin
        last_pol_q <= rail_p;
        seen_q     <= 1'b1;
      end
    end else begin
      bpv_q <= 1'b0;
      exz_q <= 1'b0;
    end
  end

  wire [1:0]     inc = {1'b0, bpv_q} + {1'b0, exz_q};
  wire [CNT_W:0] sum = {1'b0, cnt_q} + (CNT_W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (rd_clr) cnt_q <= CNT_W'(inc);
    else             cnt_q <= sum[CNT_W] ? CMAX : sum[CNT_W-1:0];
  end

  assign bpv_pulse = bpv_q;
  assign exz_pulse = exz_q;
  assign err_count = cnt_q;
endmodule

// File: rtl/lcv_monitor_chk.sv
module lcv_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             rail_p,
  input logic             rail_n,
  input logic             rd_clr,
  input logic             bpv_pulse,
  input logic             exz_pulse,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CLIM = CMAX - 2;

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> (!bpv_pulse && !exz_pulse));

  p_exz_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (rail_p ^ rail_n)) |=> !exz_pulse);

  p_cnt_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && err_count <= CLIM) |=>
      err_count == $past(err_count) + CNT_W'($past(bpv_pulse)) + CNT_W'($past(exz_pulse)));

  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && err_count == CMAX) |=> err_count == CMAX);

  p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> err_count <= CNT_W'(2));
endmodule

bind lcv_monitor lcv_monitor_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rail_p(rail_p), .rail_n(rail_n),
  .rd_clr(rd_clr), .bpv_pulse(bpv_pulse), .exz_pulse(exz_pulse), .err_count(err_count)
);

// File: tb/test_lcv_monitor.sv
module test_lcv_monitor;
  localparam int CW = 16;
  localparam int HN = 131072;
  localparam int CMAXI = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, bit_en = 1'b0, rail_p = 1'b0, rail_n = 1'b0;
  logic hdb3_mode = 1'b0, zcs_excl = 1'b0, rd_clr = 1'b0;
  logic bpv_pulse, exz_pulse;
  logic [CW-1:0] err_count;

  lcv_monitor #(.CNT_W(CW)) i_lcv_monitor (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rail_p(rail_p), .rail_n(rail_n),
    .hdb3_mode(hdb3_mode), .zcs_excl(zcs_excl), .rd_clr(rd_clr),
    .bpv_pulse(bpv_pulse), .exz_pulse(exz_pulse), .err_count(err_count)
  );

  int checks = 0, fails = 0;
  bit hm [HN];
  bit hv [HN];
  int n, zr, exp_cnt, prev_inc;
  bit lastp, seen;
  string tag_b = "R2";

  function automatic bit mk(int j);
    return (j >= 0) ? hm[j] : 1'b0;
  endfunction
  function automatic bit vl(int j);
    return (j >= 0) ? hv[j] : 1'b0;
  endfunction
  function automatic bit pat(int s);
    return !mk(s) && !mk(s+1) && !mk(s+2) && mk(s+3) && vl(s+3) && mk(s+4) && !vl(s+4)
        && !mk(s+5) && mk(s+6) && vl(s+6) && mk(s+7) && !vl(s+7);
  endfunction
  function automatic bit exp_bpv(int j);
    if (j < 0 || !vl(j)) return 1'b0;
    if (!zcs_excl) return 1'b1;
    if (hdb3_mode) return !(!mk(j-1) && !mk(j-2));
    return !(pat(j-3) || pat(j-6));
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic tick(bit en, bit p, bit q, bit r);
    bit eb, ez, m, v;
    int nc;
    eb = 1'b0; ez = 1'b0;
    bit_en = en; rail_p = p; rail_n = q; rd_clr = r;
    if (en && n < HN) begin
      m = p ^ q;
      v = m && seen && (p == lastp);
      hm[n] = m; hv[n] = v;
      if (m) begin seen = 1'b1; lastp = p; zr = 0; end
      else begin zr++; ez = (zr == (zcs_excl ? 8 : 16)); end
      n++;
      eb = exp_bpv(n - 9);
    end
    nc = r ? prev_inc : ((exp_cnt + prev_inc > CMAXI) ? CMAXI : exp_cnt + prev_inc);
    @(posedge clk);
    @(negedge clk);
    check(bpv_pulse == eb, en ? tag_b : "R7", bpv_pulse, eb);
    check(exz_pulse == ez, en ? (zcs_excl ? "R6" : "R5") : "R7", exz_pulse, ez);
    check(int'(err_count) == nc, r ? "R10" : (nc == CMAXI ? "R9" : "R8"), err_count, nc);
    exp_cnt = nc;
    prev_inc = int'(eb) + int'(ez);
  endtask

  task automatic sym(bit m, bit p, bit r = 1'b0);
    tick(1'b1, m && p, m && !p, r);
  endtask
  task automatic zeros(int k);
    for (int i = 0; i < k; i++) sym(1'b0, 1'b0);
  endtask

  task automatic do_reset(bit h, bit z);
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; rail_p = 1'b0; rail_n = 1'b0; rd_clr = 1'b0;
    hdb3_mode = h; zcs_excl = z;
    tag_b = z ? (h ? "R4" : "R3") : "R2";
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n = 0; zr = 0; seen = 1'b0; lastp = 1'b0; exp_cnt = 0; prev_inc = 0;
    @(negedge clk);
    check(err_count == '0 && !bpv_pulse && !exz_pulse, "R1",
          int'(err_count) + int'(bpv_pulse) + int'(exz_pulse), 0);
  endtask

  task automatic b8_code();
    bit l;
    l = lastp;
    zeros(3); sym(1, l); sym(1, !l); sym(1'b0, 1'b0); sym(1, !l); sym(1, l);
  endtask
  task automatic hdb_code(bit with_b);
    bit l;
    l = lastp;
    if (with_b) begin sym(1, !l); zeros(2); sym(1, !l); end
    else begin zeros(3); sym(1, l); end
  endtask

  task automatic directed_codes(bit h);
    sym(1, 1); sym(1, 0); sym(1, 1);
    if (h) begin hdb_code(1); sym(1, !lastp); hdb_code(0); end
    else b8_code();
    sym(1, !lastp);
    sym(1, lastp);
    sym(1'b0, 1'b0); sym(1, lastp);
    zeros(10);
  endtask

  task automatic random_run(int iters);
    int k;
    for (int i = 0; i < iters; i++) begin
      k = $urandom_range(0, 99);
      if (k < 8) begin
        if (hdb3_mode) hdb_code($urandom_range(0, 1) == 1); else b8_code();
      end else if (k < 16) begin
        zeros($urandom_range(6, 20));
      end else if (k < 28) begin
        tick(1'b0, 1'b0, 1'b0, $urandom_range(0, 19) == 0);
      end else if (k < 55) begin
        sym(1'b0, 1'b0, $urandom_range(0, 19) == 0);
      end else begin
        sym(1'b1, ($urandom_range(0, 9) < 7) ? !lastp : lastp, $urandom_range(0, 19) == 0);
      end
    end
    zeros(9);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin
      do_reset(c[1], c[0]);
      directed_codes(c[1]);
    end
    // R5/R6: one pulse per run at the threshold
    do_reset(1'b0, 1'b0); sym(1, 1); zeros(20); sym(1, 0); zeros(15); sym(1, 1);
    do_reset(1'b1, 1'b1); sym(1, 1); zeros(20); sym(1, 0); zeros(7); sym(1, 1);
    // R8/R10: violation exits exactly when the 8th zero lands
    do_reset(1'b0, 1'b1);
    sym(1, 1); sym(1, 1); zeros(8); zeros(1);
    sym(1, 0); sym(1, 0); zeros(7); sym(1'b0, 1'b0, 1'b0); tick(1'b0, 0, 0, 1'b1);
    sym(1, 1); sym(1, 1); zeros(7); sym(1'b0, 1'b0, 1'b1); zeros(3);
    for (int c = 0; c < 4; c++) begin
      do_reset(c[1], c[0]);
      random_run(500);
    end
    // R9: saturation with a violation on every bit, then R10 read
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < CMAXI + 20; i++) sym(1, 1);
    sym(1, 1, 1'b1);
    sym(1, 1);
    zeros(9);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule